// File: doc/BRIEF.md
# Video Memory Manager Control Register File

This block is the software-facing register file of a video memory manager. A host reaches it as an AXI4-Lite slave with a 32-bit data bus. It holds the settings for the raw video path: frame base addresses, line length in bytes and line count. It also holds the settings for the encoded video path: control word, base address and region size. Beside these it has three status views fed by the core and a control word with the path enables. Every register is 64 bits wide and sits on an 8-byte stride. Its low half is at the register offset and its high half at offset+4.

Parameters written by software go into a staging copy. That copy reads back at once, but the datapath sees a separate live copy, which is loaded only when software writes 1 to the restart bit. A running stream therefore never sees a half-updated set of values. The restart bit gives a one-cycle pulse and never reads back as 1. The path enables and the halt-on-error selector in the control word act at once.

On the bus side, the write address and write data channels are accepted on their own. A held address refuses a second address until its data arrives, and the same holds the other way round. One OKAY write response is issued once both halves have arrived. The write response waits on `s_bready` and the read data waits on `s_rready`. While a response is outstanding, no further write is performed and no further read address is accepted.

Top module: `vmm_regfile`

## Requirements
- R1: After reset every register reads 0, and `restart_pulse`, `wr_path_en`, `rd_path_en`, `halt_on_err` and all `cfg_*` outputs are 0.
- R2: A write address and write data may arrive in either order or together. While one is held without its partner, its ready is low. Exactly one write response with `s_bresp` = 2'b00 follows once both have arrived, and `s_bvalid` stays high until `s_bready`.
- R3: Each accepted read address gives one read beat with `s_rresp` = 2'b00. While `s_rready` is low, `s_rvalid` and `s_rdata` hold.
- R4: Writing the low word at offset 0x00 with bit 0 = 1 (byte lane 0 enabled) raises `restart_pulse` for exactly one cycle, in the cycle `s_bvalid` rises. Bit 0 always reads back as 0.
- R5: Bits 1, 2 and 3 of the low word at 0x00 drive `wr_path_en`, `rd_path_en` and `halt_on_err`. They take effect in the cycle the write response rises, with no restart needed.
- R6: The parameter registers (0x08, 0x10, 0x18, 0x20, 0x30, 0x38, 0x40) read back the value last written. Their `cfg_*` outputs do not change except in a restart cycle.
- R7: In the restart cycle, `cfg_frame_addr`, `cfg_frame_addr_b`, `cfg_line_bytes`, `cfg_lines`, `cfg_enc_ctrl`, `cfg_enc_base` and `cfg_enc_size` take the values staged at 0x08, 0x10, 0x18, 0x20, 0x30, 0x38 and 0x40 respectively.
- R8: Each 64-bit register is reached as bits 31:0 at its offset and bits 63:32 at offset+4.
- R9: Only the byte lanes whose `s_wstrb` bit is set are changed by a write.
- R10: Offset 0x28 reads `raw_status` and offset 0x50 reads `enc_last_addr`. Writes to them get OKAY and change nothing.
- R11: Offsets 0x58 and above read 0, and writes to them get OKAY and change nothing. Bits 63:4 of 0x00 read 0.
- R12: Offset 0x48 is a sticky flag register. A bit is set in any cycle where `enc_status_set` has that bit high, and cleared by writing 1 to it. When both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte lanes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| raw_status | input | 64 | Raw path status shown at 0x28 |
| enc_status_set | input | 64 | Set pulses for the sticky flags at 0x48 |
| enc_last_addr | input | 64 | Last encoded address shown at 0x50 |
| restart_pulse | output | 1 | One-cycle restart strobe |
| wr_path_en | output | 1 | Write path enable |
| rd_path_en | output | 1 | Read path enable |
| halt_on_err | output | 1 | Halt-on-error select |
| cfg_frame_addr | output | 64 | Live raw frame address |
| cfg_frame_addr_b | output | 64 | Live raw frame byte address |
| cfg_line_bytes | output | 64 | Live line length in bytes |
| cfg_lines | output | 64 | Live line count |
| cfg_enc_ctrl | output | 64 | Live encoded control word |
| cfg_enc_base | output | 64 | Live encoded region base |
| cfg_enc_size | output | 64 | Live encoded region size |

## Verification
The case hardest to reach from the ports is a sticky flag being set and cleared in the same cycle. The clear lands on one edge that depends on the channel timing. The stimulus therefore holds one `enc_status_set` bit high across the whole clearing write, so the collision edge is covered whatever the channel latency turns out to be. The staged-versus-live split also needs care. A parameter is read back and the `cfg_*` outputs are sampled both before and in the exact cycle of the restart response. The bench also holds `s_rready` low for several cycles to observe read data being held, and it offers a write address without its data to see the address channel refuse more.

// File: rtl/vmm_regfile_pkg.sv
package vmm_regfile_pkg;
  // register slots, one every 8 bytes
  localparam int NSLOT    = 11;
  localparam int SL_CTRL  = 0;
  localparam int SL_FADDR = 1;
  localparam int SL_FADRB = 2;
  localparam int SL_LBYTE = 3;
  localparam int SL_LINES = 4;
  localparam int SL_RSTAT = 5;
  localparam int SL_ECTRL = 6;
  localparam int SL_EBASE = 7;
  localparam int SL_ESIZE = 8;
  localparam int SL_ESTAT = 9;
  localparam int SL_ELAST = 10;

  // slots that are staged and shadowed
  localparam logic [NSLOT-1:0] PARAM_MASK = 11'b00111011110;

  // control word bit positions
  localparam int CB_RESTART = 0;
  localparam int CB_WREN    = 1;
  localparam int CB_RDEN    = 2;
  localparam int CB_HALT    = 3;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/vmm_regfile_wr.sv
module vmm_regfile_wr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  import vmm_regfile_pkg::*;

  logic aw_full, w_full, b_q;

  assign awready = !aw_full;
  assign wready  = !w_full;
  assign wr_fire = aw_full && w_full && !b_q;
  assign bvalid  = b_q;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      b_q     <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      if (awvalid && !aw_full) begin
        aw_full <= 1'b1;
        wr_addr <= awaddr;
      end else if (wr_fire) begin
        aw_full <= 1'b0;
      end
      if (wvalid && !w_full) begin
        w_full  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end else if (wr_fire) begin
        w_full <= 1'b0;
      end
      if (wr_fire)     b_q <= 1'b1;
      else if (bready) b_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vmm_regfile_rd.sv
module vmm_regfile_rd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic [DATA_W-1:0] lk_data
);
  import vmm_regfile_pkg::*;

  logic r_q;

  assign arready = !r_q;
  assign rvalid  = r_q;
  assign rresp   = RESP_OKAY;
  assign lk_addr = araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q   <= 1'b0;
      rdata <= '0;
    end else if (arvalid && !r_q) begin
      r_q   <= 1'b1;
      rdata <= lk_data;
    end else if (rready) begin
      r_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vmm_regfile_bank.sv
module vmm_regfile_bank
  import vmm_regfile_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 64,
  localparam int DATA_W = REG_W / 2,
  localparam int STRB_W = DATA_W / 8,
  localparam int SLOT_W = ADDR_W - 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [STRB_W-1:0]           wr_strb,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  input  logic [REG_W-1:0]            raw_status,
  input  logic [REG_W-1:0]            enc_set,
  input  logic [REG_W-1:0]            enc_last,
  output logic                        restart_o,
  output logic                        wren_o,
  output logic                        rden_o,
  output logic                        halt_o,
  output logic [NSLOT-1:0][REG_W-1:0] cfg_o
);

  function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old,
                                            input logic hi,
                                            input logic [DATA_W-1:0] d,
                                            input logic [STRB_W-1:0] s);
    logic [REG_W-1:0] r;
    int base;
    r = old;
    base = hi ? DATA_W : 0;
    for (int b = 0; b < STRB_W; b++)
      if (s[b]) r[base + 8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic              wr_hi, rd_hi, wr_hit, rd_hit, restart_fire;
  logic [2:0]        ctrl_q;
  logic              restart_q;
  logic [REG_W-1:0]  sticky_q, sticky_clr;
  logic [REG_W-1:0]  slot_rd [NSLOT];
  logic              unused_lsb;

  assign wr_slot = wr_addr[ADDR_W-1:3];
  assign rd_slot = rd_addr[ADDR_W-1:3];
  assign wr_hi   = wr_addr[2];
  assign rd_hi   = rd_addr[2];
  assign wr_hit  = wr_fire && (int'(wr_slot) < NSLOT);
  assign rd_hit  = int'(rd_slot) < NSLOT;
  assign unused_lsb = ^{wr_addr[1:0], rd_addr[1:0]};

  assign restart_fire = wr_hit && (int'(wr_slot) == SL_CTRL) && !wr_hi &&
                        wr_strb[0] && wr_data[CB_RESTART];

  // control word: enables act at once, restart is a pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= restart_fire;
      if (wr_hit && (int'(wr_slot) == SL_CTRL) && !wr_hi && wr_strb[0])
        ctrl_q <= wr_data[CB_HALT:CB_WREN];
    end
  end
  assign restart_o = restart_q;
  assign wren_o    = ctrl_q[CB_WREN-1];
  assign rden_o    = ctrl_q[CB_RDEN-1];
  assign halt_o    = ctrl_q[CB_HALT-1];

  // sticky flags: write one to clear, set has priority
  assign sticky_clr = (wr_hit && (int'(wr_slot) == SL_ESTAT)) ?
                      merge('0, wr_hi, wr_data, wr_strb) : '0;
  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~sticky_clr) | enc_set;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (PARAM_MASK[s]) begin : g_par
      logic [REG_W-1:0] stage_q, live_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q <= '0;
          live_q  <= '0;
        end else begin
          if (wr_hit && (int'(wr_slot) == s))
            stage_q <= merge(stage_q, wr_hi, wr_data, wr_strb);
          if (restart_fire)
            live_q <= stage_q;
        end
      end
      assign slot_rd[s] = stage_q;
      assign cfg_o[s]   = live_q;
    end else begin : g_fix
      assign cfg_o[s] = '0;
      if (s == SL_CTRL) begin : g_ctrl
        assign slot_rd[s] = {{(REG_W-4){1'b0}}, ctrl_q, 1'b0};
      end else if (s == SL_RSTAT) begin : g_rstat
        assign slot_rd[s] = raw_status;
      end else if (s == SL_ESTAT) begin : g_estat
        assign slot_rd[s] = sticky_q;
      end else begin : g_elast
        assign slot_rd[s] = enc_last;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit)
      rd_data = rd_hi ? slot_rd[rd_slot][REG_W-1:DATA_W]
                      : slot_rd[rd_slot][DATA_W-1:0];
  end
endmodule

// File: rtl/vmm_regfile.sv
module vmm_regfile
  import vmm_regfile_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 64,
  localparam int DATA_W = REG_W / 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [REG_W-1:0]  raw_status,
  input  logic [REG_W-1:0]  enc_status_set,
  input  logic [REG_W-1:0]  enc_last_addr,
  output logic              restart_pulse,
  output logic              wr_path_en,
  output logic              rd_path_en,
  output logic              halt_on_err,
  output logic [REG_W-1:0]  cfg_frame_addr,
  output logic [REG_W-1:0]  cfg_frame_addr_b,
  output logic [REG_W-1:0]  cfg_line_bytes,
  output logic [REG_W-1:0]  cfg_lines,
  output logic [REG_W-1:0]  cfg_enc_ctrl,
  output logic [REG_W-1:0]  cfg_enc_base,
  output logic [REG_W-1:0]  cfg_enc_size
);

  logic                        wr_fire;
  logic [ADDR_W-1:0]           wr_addr, lk_addr;
  logic [DATA_W-1:0]           wr_data, lk_data;
  logic [STRB_W-1:0]           wr_strb;
  logic [NSLOT-1:0][REG_W-1:0] cfg;
  logic                        unused_cfg;

  vmm_regfile_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  vmm_regfile_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .lk_addr(lk_addr), .lk_data(lk_data)
  );

  vmm_regfile_bank #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(lk_addr), .rd_data(lk_data),
    .raw_status(raw_status), .enc_set(enc_status_set), .enc_last(enc_last_addr),
    .restart_o(restart_pulse), .wren_o(wr_path_en), .rden_o(rd_path_en),
    .halt_o(halt_on_err), .cfg_o(cfg)
  );

  assign cfg_frame_addr   = cfg[SL_FADDR];
  assign cfg_frame_addr_b = cfg[SL_FADRB];
  assign cfg_line_bytes   = cfg[SL_LBYTE];
  assign cfg_lines        = cfg[SL_LINES];
  assign cfg_enc_ctrl     = cfg[SL_ECTRL];
  assign cfg_enc_base     = cfg[SL_EBASE];
  assign cfg_enc_size     = cfg[SL_ESIZE];
  assign unused_cfg = ^{cfg[SL_CTRL], cfg[SL_RSTAT], cfg[SL_ESTAT], cfg[SL_ELAST]};
endmodule

// File: rtl/vmm_regfile_chk.sv
module vmm_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [1:0]        s_rresp,
  input logic [DATA_W-1:0] s_rdata,
  input logic              restart_pulse,
  input logic [REG_W-1:0]  cfg_frame_addr,
  input logic [REG_W-1:0]  cfg_line_bytes,
  input logic [REG_W-1:0]  cfg_lines,
  input logic [REG_W-1:0]  cfg_enc_size
);
  AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> s_bresp == 2'b00); // R2
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid); // R2
  AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == 2'b00); // R3
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R3
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse); // R4
  AST_RESTART_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> s_bvalid); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_pulse |-> $stable(cfg_frame_addr) && $stable(cfg_line_bytes) &&
                       $stable(cfg_lines) && $stable(cfg_enc_size)); // R6
endmodule

bind vmm_regfile vmm_regfile_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rresp(s_rresp), .s_rdata(s_rdata),
  .restart_pulse(restart_pulse), .cfg_frame_addr(cfg_frame_addr),
  .cfg_line_bytes(cfg_line_bytes), .cfg_lines(cfg_lines), .cfg_enc_size(cfg_enc_size)
);

// File: tb/vmm_regfile_test.sv
`timescale 1ns/1ps
module vmm_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
  logic        s_bready = 1'b1, s_rready = 1'b1;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [63:0] raw_status = '0, enc_status_set = '0, enc_last_addr = '0;
  logic        restart_pulse, wr_path_en, rd_path_en, halt_on_err;
  logic [63:0] cfg_frame_addr, cfg_frame_addr_b, cfg_line_bytes, cfg_lines;
  logic [63:0] cfg_enc_ctrl, cfg_enc_base, cfg_enc_size;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic pulse_at_b, pulse_after;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  vmm_regfile uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read beat
  always @(negedge clk) begin
    if (rst_n && s_rvalid && s_rready) begin
      if (exp_q.size() == 0) chk("R3 unexpected beat", 64'(s_rdata), 64'hX);
      else begin
        chk(tag_q.pop_front(), 64'(s_rdata), 64'(exp_q.pop_front()));
        chk("R3 rresp", 64'(s_rresp), 64'h0);
      end
    end
  end

  task automatic send_aw(input logic [7:0] a);
    s_awaddr = a; s_awvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk); s_awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
    while (!s_wready) @(negedge clk);
    @(negedge clk); s_wvalid = 1'b0;
  endtask

  task automatic wait_b();
    while (!s_bvalid) @(negedge clk);
    pulse_at_b = restart_pulse;
    chk("R2 bresp", 64'(s_bresp), 64'h0);
    @(negedge clk);
    pulse_after = restart_pulse;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    if (order == 0) fork send_aw(a); send_w(d, s); join
    else if (order == 1) begin send_aw(a); repeat (2) @(negedge clk); send_w(d, s); end
    else begin send_w(d, s); repeat (2) @(negedge clk); send_aw(a); end
    wait_b();
  endtask

  task automatic rd_issue(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk); s_arvalid = 1'b0;
  endtask

  task automatic rd_wait();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_issue(a, e, tag); rd_wait();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 restart_pulse", 64'(restart_pulse), 0);
    chk("R1 enables", 64'({wr_path_en, rd_path_en, halt_on_err}), 0);
    chk("R1 cfg_line_bytes", cfg_line_bytes, 0);
    chk("R1 cfg_enc_size", cfg_enc_size, 0);
    rd(8'h00, 0, "R1 ctrl");
    rd(8'h18, 0, "R1 line bytes");
    rd(8'h4C, 0, "R1 sticky hi");

    // R2 and R8: both channel orders, 64-bit halves
    wr(8'h18, 32'h0000_0780, 4'hF, 1);
    wr(8'h1C, 32'h0000_0001, 4'hF, 2);
    rd(8'h18, 32'h0000_0780, "R8 low half");
    rd(8'h1C, 32'h0000_0001, "R8 high half");
    chk("R6 cfg_line_bytes before restart", cfg_line_bytes, 0);

    // R2 held address blocks a second one
    send_aw(8'h20);
    chk("R2 awready low while held", 64'(s_awready), 0);
    chk("R2 no response without data", 64'(s_bvalid), 0);
    send_w(32'h0000_0870, 4'hF);
    wait_b();
    rd(8'h20, 32'h0000_0870, "R6 lines staged");

    // R9 byte lanes
    wr(8'h08, 32'h1122_3344, 4'hF, 0);
    wr(8'h08, 32'hAABB_CCDD, 4'b0011, 0);
    rd(8'h08, 32'h1122_CCDD, "R9 partial strobe");
    wr(8'h44, 32'h0000_0002, 4'hF, 0);

    // R5 enables act at once
    wr(8'h00, 32'h0000_0006, 4'hF, 0);
    chk("R5 wr_path_en", 64'(wr_path_en), 1);
    chk("R5 rd_path_en", 64'(rd_path_en), 1);
    chk("R5 halt_on_err", 64'(halt_on_err), 0);
    chk("R4 no pulse without bit0", 64'(pulse_at_b), 0);
    chk("R6 cfg_lines unchanged", cfg_lines, 0);

    // R4 and R7 restart
    wr(8'h00, 32'h0000_0007, 4'hF, 0);
    chk("R4 pulse with response", 64'(pulse_at_b), 1);
    chk("R4 pulse one cycle", 64'(pulse_after), 0);
    chk("R7 cfg_line_bytes", cfg_line_bytes, 64'h1_0000_0780);
    chk("R7 cfg_lines", cfg_lines, 64'h870);
    chk("R7 cfg_frame_addr", cfg_frame_addr, 64'h1122_CCDD);
    chk("R7 cfg_enc_size", cfg_enc_size, 64'h2_0000_0000);
    rd(8'h00, 32'h0000_0006, "R4 bit0 reads zero");

    // R6 new stage not live until next restart
    wr(8'h18, 32'h0000_0F00, 4'hF, 0);
    chk("R6 cfg held after stage write", cfg_line_bytes, 64'h1_0000_0780);

    // R11 reserved bits
    wr(8'h00, 32'hFFFF_FFF8, 4'hF, 0);
    chk("R5 halt set", 64'({wr_path_en, rd_path_en, halt_on_err}), 64'b001);
    rd(8'h00, 32'h0000_0008, "R11 reserved low");
    wr(8'h04, 32'hFFFF_FFFF, 4'hF, 0);
    rd(8'h04, 0, "R11 reserved high");

    // R10 read-only status
    raw_status = 64'h0123_4567_89AB_CDEF;
    enc_last_addr = 64'h0000_00FE_DCBA_0000;
    rd(8'h28, 32'h89AB_CDEF, "R10 raw status low");
    wr(8'h28, 32'h0, 4'hF, 0);
    rd(8'h2C, 32'h0123_4567, "R10 raw status high after write");
    wr(8'h54, 32'h0, 4'hF, 0);
    rd(8'h54, 32'h0000_00FE, "R10 last addr high");

    // R11 unmapped
    wr(8'h58, 32'hDEAD_BEEF, 4'hF, 0);
    rd(8'h58, 0, "R11 unmapped 0x58");
    wr(8'hF0, 32'hDEAD_BEEF, 4'hF, 0);
    rd(8'hF0, 0, "R11 unmapped 0xF0");

    // R12 sticky flags
    enc_status_set = 64'h5;
    @(negedge clk);
    enc_status_set = '0;
    repeat (2) @(negedge clk);
    rd(8'h48, 32'h5, "R12 sticky set");
    enc_status_set = 64'h2;
    wr(8'h48, 32'hFFFF_FFFF, 4'hF, 0);
    enc_status_set = '0;
    rd(8'h48, 32'h2, "R12 set beats clear");
    wr(8'h48, 32'h0000_0002, 4'hF, 0);
    rd(8'h48, 32'h0, "R12 clear");

    // R3 read back-pressure
    s_rready = 1'b0;
    rd_issue(8'h20, 32'h0000_0870, "R3 beat after stall");
    repeat (3) @(negedge clk);
    chk("R3 rvalid held", 64'(s_rvalid), 1);
    chk("R3 rdata held", 64'(s_rdata), 64'h870);
    s_rready = 1'b1;
    rd_wait();

    // R7 second restart picks new stage, clears enables
    wr(8'h00, 32'h0000_0001, 4'b0001, 0);
    chk("R7 second restart line bytes", cfg_line_bytes, 64'h1_0000_0F00);
    chk("R5 enables cleared", 64'({wr_path_en, rd_path_en, halt_on_err}), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule